// File: doc/BRIEF.md
# Floating-Point Special-Value Conditioning Unit

This block wraps a single-precision arithmetic datapath. On the way in, it inspects two IEEE-754 operands. When the flush-to-zero control bit is set, it replaces any subnormal operand with positive zero. On the way out, it takes the datapath's unrounded result, given as a sign, a signed biased exponent and an explicit-leading-bit significand, and packs it into a single-precision word. While packing, it substitutes the fixed default NaN when that mode is on, and it flushes results below the normal range to a signed zero when flush-to-zero is on.

The block also holds the status/control register. This register carries the two mode bits, two trap enables and three sticky exception flags. Software reads and writes the register through a one-cycle write port with a combinational read-back. Operand conditioning, result packing and the trap request are combinational. Flag updates land on the next clock edge.

Top module: `fpsv_cond`

## Requirements
- R1: With flush-to-zero on (status bit 24), an operand whose exponent field is 0 and whose fraction is non-zero appears on its conditioned output as 0x00000000, whatever its sign. All other operands, and every operand while bit 24 is clear, pass through unchanged.
- R2: The input-subnormal flag (status bit 7) becomes set one cycle after an `op_valid` cycle in which flush-to-zero is on and at least one operand is subnormal. Zero operands never set it, and neither does any operand while flush-to-zero is off.
- R3: `op_trap` is high in the same cycle as an `op_valid` in which the input-subnormal trap enable (status bit 15) is set and at least one operand is subnormal. This holds whether flush-to-zero is on or off.
- R4: For a NaN result (`res_nan` high), `res_out` is 0x7FC00000 when default-NaN mode (status bit 25) is on. When that mode is off, `res_out` is {`res_sign`, exponent all ones, fraction bit 22 forced to 1, fraction bits 21:0 taken from `res_sig[21:0]`}.
- R5: A non-NaN result with a non-zero significand and `res_exp` below 1 is tiny. With flush-to-zero on, it packs to {`res_sign`, 31 zero bits}, and the underflow flag (status bit 3) becomes set on the next edge when `res_valid` was high.
- R6: The underflow trap enable (status bit 11) never raises `op_trap`. `op_trap` is low whenever `op_valid` is low.
- R7: The inexact flag (status bit 4) is set only by a `res_valid` cycle with `res_inexact` high. Flushing an input or a result never sets it.
- R8: Flags are sticky. Once set, a flag stays set until a software write, and a software write loads every writable bit from `csr_wdata`.
- R9: When a software write and a hardware flag update fall in the same cycle, the register takes exactly the written value.
- R10: Bits 25, 24, 15, 11, 7, 4 and 3 are read/write. Every other bit reads 0, and the register resets to 0.
- R11: A non-NaN result with a non-zero significand packs to signed infinity when `res_exp` ≥ 255, and to {sign, `res_exp[7:0]`, `res_sig[22:0]`} when `res_exp` is in 1..254. A result with a zero significand packs to a signed zero. A tiny result with flush-to-zero off packs to exponent 0 and fraction (`res_sig` >> (1 − `res_exp`))[22:0], and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 32 | Status register write data |
| csr_rdata | output | 32 | Status register contents |
| op_valid | input | 1 | Operands presented for an operation |
| op_a | input | 32 | First raw operand |
| op_b | input | 32 | Second raw operand |
| op_a_out | output | 32 | First conditioned operand |
| op_b_out | output | 32 | Second conditioned operand |
| op_trap | output | 1 | Undefined-instruction trap request |
| res_valid | input | 1 | Result presented by the datapath |
| res_sign | input | 1 | Result sign |
| res_exp | input | 10 | Signed biased result exponent, unrounded |
| res_sig | input | 24 | Result significand, bit 23 is the leading bit |
| res_nan | input | 1 | Result is NaN; fraction payload in `res_sig[21:0]` |
| res_inexact | input | 1 | Datapath reports an inexact result |
| res_out | output | 32 | Packed single-precision result |

## Verification
A software write to the status register can land in the same cycle as a hardware flag update from a flushed operand, a flushed result or an inexact report. The bench provokes this by raising `csr_we` on the very cycle that carries a subnormal operand under flush-to-zero, or a non-inexact result. It then reads the register back after the edge, and the read-back must equal the written value under the writable-bit mask, whichever way the hardware event pointed. The sweeps also present operands and results together with the underflow and input-subnormal enables both set, so that the trap request is judged against the input condition alone.

// File: rtl/fpsv_pkg.sv
package fpsv_pkg;
   // Status register bit positions (software-visible layout)
   localparam int BIT_UFC = 3;
   localparam int BIT_IXC = 4;
   localparam int BIT_IDC = 7;
   localparam int BIT_UFE = 11;
   localparam int BIT_IDE = 15;
   localparam int BIT_FTZ = 24;
   localparam int BIT_DN  = 25;

   localparam int CSR_W = 32;

   function automatic logic [CSR_W-1:0] csr_wmask();
      logic [CSR_W-1:0] m;
      m = '0;
      m[BIT_UFC] = 1'b1;
      m[BIT_IXC] = 1'b1;
      m[BIT_IDC] = 1'b1;
      m[BIT_UFE] = 1'b1;
      m[BIT_IDE] = 1'b1;
      m[BIT_FTZ] = 1'b1;
      m[BIT_DN]  = 1'b1;
      return m;
   endfunction

   typedef struct packed {
      logic set_ufc;
      logic set_ixc;
      logic set_idc;
   } flag_evt_t;
endpackage

// File: rtl/fpsv_in_cond.sv
module fpsv_in_cond #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ftz,
   input  logic [EXP_W+MAN_W:0]     op_in,
   output logic [EXP_W+MAN_W:0]     op_out,
   output logic                     is_sub
);
   localparam int W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f  = op_in[W-2:MAN_W];
   assign man_f  = op_in[MAN_W-1:0];
   assign is_sub = (exp_f == '0) && (man_f != '0);

   always_comb begin
      if (ftz && is_sub) op_out = '0;
      else               op_out = op_in;
   end

   // R1: a flushed operand is always positive zero
   assert_flush_pos_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ftz && (op_in[W-2:MAN_W] == '0) && (op_in[MAN_W-1:0] != '0)) |-> (op_out == '0));

   // R1: non-subnormal operands are never altered
   assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !((op_in[W-2:MAN_W] == '0) && (op_in[MAN_W-1:0] != '0)) |-> (op_out == op_in));
endmodule

// File: rtl/fpsv_out_cond.sv
module fpsv_out_cond #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ftz,
   input  logic                     dn,
   input  logic                     res_sign,
   input  logic signed [EXP_W+1:0]  res_exp,
   input  logic [MAN_W:0]           res_sig,
   input  logic                     res_nan,
   output logic [EXP_W+MAN_W:0]     res_out,
   output logic                     flushed
);
   localparam int W    = 1 + EXP_W + MAN_W;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam int SW   = EXP_W + 3;
   localparam logic [W-1:0] DNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic signed [SW-1:0] sh;
   logic [MAN_W:0]       shifted;
   logic                 is_tiny;
   logic                 is_huge;

   assign is_tiny = res_exp < $signed((EXP_W+2)'(1));
   assign is_huge = res_exp >= $signed((EXP_W+2)'(EMAX));
   assign sh      = $signed(SW'(1)) - $signed({res_exp[EXP_W+1], res_exp});

   always_comb begin
      if (sh > $signed(SW'(MAN_W))) shifted = '0;
      else                          shifted = res_sig >> sh[SW-2:0];
   end

   always_comb begin
      flushed = 1'b0;
      if (res_nan) begin
         if (dn) res_out = DNAN;
         else    res_out = {res_sign, {EXP_W{1'b1}}, 1'b1, res_sig[MAN_W-2:0]};
      end else if (res_sig == '0) begin
         res_out = {res_sign, {(W-1){1'b0}}};
      end else if (is_huge) begin
         res_out = {res_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end else if (is_tiny) begin
         if (ftz) begin
            res_out = {res_sign, {(W-1){1'b0}}};
            flushed = 1'b1;
         end else begin
            res_out = {res_sign, {EXP_W{1'b0}}, shifted[MAN_W-1:0]};
         end
      end else begin
         res_out = {res_sign, res_exp[EXP_W-1:0], res_sig[MAN_W-1:0]};
      end
   end

   // R5: a tiny result under flush-to-zero becomes a signed zero
   assert_tiny_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ftz && !res_nan && (res_sig != '0) && (res_exp < $signed((EXP_W+2)'(1))))
      |-> (res_out == {res_sign, {(W-1){1'b0}}}));

   // R4: default-NaN mode yields one fixed encoding
   assert_dn_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn && res_nan) |-> (res_out == DNAN));
endmodule

// File: rtl/fpsv_csr.sv
module fpsv_csr
   import fpsv_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [CSR_W-1:0]  csr_wdata,
   input  flag_evt_t         evt,
   output logic [CSR_W-1:0]  csr_q
);
   localparam logic [CSR_W-1:0] WMASK = csr_wmask();

   logic [CSR_W-1:0] set_vec;

   always_comb begin
      set_vec          = '0;
      set_vec[BIT_IDC] = evt.set_idc;
      set_vec[BIT_UFC] = evt.set_ufc;
      set_vec[BIT_IXC] = evt.set_ixc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      csr_q <= '0;
      else if (csr_we) csr_q <= csr_wdata & WMASK;
      else             csr_q <= csr_q | set_vec;
   end

   // R8: set flags hold without a write
   assert_sticky_idc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && csr_q[BIT_IDC]) |=> csr_q[BIT_IDC]);
   assert_sticky_ufc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && csr_q[BIT_UFC]) |=> csr_q[BIT_UFC]);
   assert_sticky_ixc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && csr_q[BIT_IXC]) |=> csr_q[BIT_IXC]);

   // R9: a write wins over any simultaneous flag event
   assert_sw_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |=> (csr_q == ($past(csr_wdata) & WMASK)));

   // R10: unwritable bits stay zero
   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((csr_q & ~WMASK) == '0));
endmodule

// File: rtl/fpsv_cond.sv
module fpsv_cond
   import fpsv_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int N_OPS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       csr_we,
   input  logic [31:0]                csr_wdata,
   output logic [31:0]                csr_rdata,
   input  logic                       op_valid,
   input  logic [EXP_W+MAN_W:0]       op_a,
   input  logic [EXP_W+MAN_W:0]       op_b,
   output logic [EXP_W+MAN_W:0]       op_a_out,
   output logic [EXP_W+MAN_W:0]       op_b_out,
   output logic                       op_trap,
   input  logic                       res_valid,
   input  logic                       res_sign,
   input  logic signed [EXP_W+1:0]    res_exp,
   input  logic [MAN_W:0]             res_sig,
   input  logic                       res_nan,
   input  logic                       res_inexact,
   output logic [EXP_W+MAN_W:0]       res_out
);
   localparam int W = 1 + EXP_W + MAN_W;

   if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
      $error("fpsv_cond: exponent and fraction need at least two bits");
   end
   if (N_OPS != 2) begin : g_bad_ops
      $error("fpsv_cond: the port list carries exactly two operands");
   end
   if (CSR_W != 32 || BIT_DN >= CSR_W) begin : g_bad_csr
      $error("fpsv_cond: status register layout does not fit");
   end

   logic [CSR_W-1:0] csr_q;
   logic [W-1:0]     ops_in  [N_OPS];
   logic [W-1:0]     ops_out [N_OPS];
   logic [N_OPS-1:0] sub_vec;
   logic             ftz, dn, ide;
   logic             res_flushed;
   flag_evt_t        evt;

   assign ftz = csr_q[BIT_FTZ];
   assign dn  = csr_q[BIT_DN];
   assign ide = csr_q[BIT_IDE];

   assign ops_in[0] = op_a;
   assign ops_in[1] = op_b;
   assign op_a_out  = ops_out[0];
   assign op_b_out  = ops_out[1];

   for (genvar gi = 0; gi < N_OPS; gi++) begin : g_op
      fpsv_in_cond #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_in (
         .clk    (clk),
         .rst_n  (rst_n),
         .ftz    (ftz),
         .op_in  (ops_in[gi]),
         .op_out (ops_out[gi]),
         .is_sub (sub_vec[gi])
      );
   end

   fpsv_out_cond #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ftz      (ftz),
      .dn       (dn),
      .res_sign (res_sign),
      .res_exp  (res_exp),
      .res_sig  (res_sig),
      .res_nan  (res_nan),
      .res_out  (res_out),
      .flushed  (res_flushed)
   );

   assign evt.set_idc = op_valid && ftz && (|sub_vec);
   assign evt.set_ufc = res_valid && res_flushed;
   assign evt.set_ixc = res_valid && res_inexact;

   assign op_trap = op_valid && ide && (|sub_vec);

   fpsv_csr u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_wdata (csr_wdata),
      .evt       (evt),
      .csr_q     (csr_q)
   );

   assign csr_rdata = csr_q;

   // R6: a trap needs a live operation and the input-subnormal enable
   assert_trap_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_trap |-> (op_valid && csr_rdata[BIT_IDE]));

   // R3: enable plus a subnormal operand always requests the trap
   assert_trap_raised_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && csr_rdata[BIT_IDE] &&
       (((op_a[W-2:MAN_W] == '0) && (op_a[MAN_W-1:0] != '0)) ||
        ((op_b[W-2:MAN_W] == '0) && (op_b[MAN_W-1:0] != '0)))) |-> op_trap);

   // R7: without an inexact report and without a write, the inexact flag stays clear
   assert_ixc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && !csr_rdata[BIT_IXC] && !(res_valid && res_inexact)) |=> !csr_rdata[BIT_IXC]);

   // R2: with flush-to-zero off, no write and no prior flag, the input flag stays clear
   assert_idc_needs_ftz_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && !csr_rdata[BIT_FTZ] && !csr_rdata[BIT_IDC]) |=> !csr_rdata[BIT_IDC]);
endmodule

// File: tb/sim_fpsv_cond.sv
module sim_fpsv_cond;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              csr_we = 1'b0;
   logic [31:0]       csr_wdata = '0;
   logic [31:0]       csr_rdata;
   logic              op_valid = 1'b0;
   logic [31:0]       op_a = '0, op_b = '0;
   logic [31:0]       op_a_out, op_b_out;
   logic              op_trap;
   logic              res_valid = 1'b0;
   logic              res_sign = 1'b0;
   logic signed [9:0] res_exp = '0;
   logic [23:0]       res_sig = '0;
   logic              res_nan = 1'b0;
   logic              res_inexact = 1'b0;
   logic [31:0]       res_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   localparam logic [31:0] MASK = (32'd1 << 25) | (32'd1 << 24) | (32'd1 << 15) |
                                  (32'd1 << 11) | (32'd1 << 7) | (32'd1 << 4) | (32'd1 << 3);

   always #2 clk = ~clk;

   fpsv_cond u0 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .op_valid(op_valid), .op_a(op_a), .op_b(op_b), .op_a_out(op_a_out), .op_b_out(op_b_out),
      .op_trap(op_trap), .res_valid(res_valid), .res_sign(res_sign), .res_exp(res_exp),
      .res_sig(res_sig), .res_nan(res_nan), .res_inexact(res_inexact), .res_out(res_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic bit is_sub(input logic [31:0] v);
      return (v[30:23] == 8'd0) && (v[22:0] != 23'd0);
   endfunction

   // writes a configuration; returns at the negedge after the write has landed
   task automatic cfg(input logic [31:0] v);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = v;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic op_vec(input logic [31:0] a, input logic [31:0] b, input bit ftz, input bit ide);
      logic [31:0] c;
      logic [31:0] ea, eb;
      c = (ftz ? (32'd1 << 24) : 32'd0) | (ide ? (32'd1 << 15) : 32'd0) | (32'd1 << 11);
      cfg(c);
      op_valid = 1'b1; op_a = a; op_b = b;
      #1;
      ea = (ftz && is_sub(a)) ? 32'd0 : a;
      eb = (ftz && is_sub(b)) ? 32'd0 : b;
      check("R1 operand a", op_a_out, ea);
      check("R1 operand b", op_b_out, eb);
      check("R3 R6 trap", {31'd0, op_trap}, {31'd0, ide && (is_sub(a) || is_sub(b))});
      @(negedge clk);
      op_valid = 1'b0;
      #1;
      check("R2 R7 input flag", csr_rdata,
            c | ((ftz && (is_sub(a) || is_sub(b))) ? (32'd1 << 7) : 32'd0));
   endtask

   function automatic logic [31:0] exp_res(input bit s, input int e, input logic [23:0] sg,
                                           input bit nan, input bit ftz, input bit dn);
      int sh;
      logic [23:0] t;
      if (nan) return dn ? 32'h7FC00000 : {s, 8'hFF, 1'b1, sg[21:0]};
      if (sg == 0) return {s, 31'd0};
      if (e >= 255) return {s, 8'hFF, 23'd0};
      if (e < 1) begin
         if (ftz) return {s, 31'd0};
         sh = 1 - e;
         t = (sh > 23) ? 24'd0 : (sg >> sh);
         return {s, 8'd0, t[22:0]};
      end
      return {s, e[7:0], sg[22:0]};
   endfunction

   task automatic res_vec(input bit s, input int e, input logic [23:0] sg, input bit nan,
                          input bit ftz, input bit dn, input bit ix);
      logic [31:0] c;
      bit uf;
      c = (ftz ? (32'd1 << 24) : 32'd0) | (dn ? (32'd1 << 25) : 32'd0) |
          (32'd1 << 11) | (32'd1 << 15);
      cfg(c);
      res_valid = 1'b1; res_sign = s; res_exp = 10'(e); res_sig = sg;
      res_nan = nan; res_inexact = ix;
      #1;
      check("R4 R5 R11 packed result", res_out, exp_res(s, e, sg, nan, ftz, dn));
      check("R6 no trap from result", {31'd0, op_trap}, 32'd0);
      @(negedge clk);
      res_valid = 1'b0;
      #1;
      uf = ftz && !nan && (sg != 0) && (e < 1);
      check("R5 R7 result flags", csr_rdata,
            c | (uf ? (32'd1 << 3) : 32'd0) | (ix ? (32'd1 << 4) : 32'd0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  exps [4];
      logic [22:0] mans [4];
      int          rexp [8];
      logic [23:0] rsig [5];
      exps = '{8'd0, 8'd1, 8'd254, 8'd255};
      mans = '{23'd0, 23'd1, 23'h400000, 23'h7FFFFF};
      rexp = '{-30, -1, 0, 1, 127, 254, 255, 300};
      rsig = '{24'd0, 24'h800000, 24'hFFFFFF, 24'h800001, 24'h000003};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R10 reset value", csr_rdata, 32'd0);

      // R10: writable mask
      cfg(32'hFFFFFFFF);
      #1;
      check("R10 writable bits", csr_rdata, MASK);

      // operand sweep (R1 R2 R3 R6)
      for (int ai = 0; ai < 16; ai++)
         for (int sa = 0; sa < 2; sa++)
            for (int bi = 0; bi < 16; bi++)
               for (int m = 0; m < 4; m++)
                  op_vec({sa[0], exps[ai/4], mans[ai%4]},
                         {bi[0], exps[bi/4], mans[bi%4]}, m[0], m[1]);

      // result sweep (R4 R5 R6 R7 R11)
      for (int ei = 0; ei < 8; ei++)
         for (int si = 0; si < 5; si++)
            for (int m = 0; m < 32; m++)
               res_vec(m[0], rexp[ei], rsig[si], m[1], m[2], m[3], m[4]);

      // R8: sticky input flag survives quiet operations, clears on write
      op_vec(32'h00000005, 32'h3F800000, 1'b1, 1'b0);
      @(negedge clk);
      op_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h40000000;
      repeat (3) @(negedge clk);
      op_valid = 1'b0;
      #1;
      check("R8 flag held", csr_rdata, (32'd1 << 24) | (32'd1 << 11) | (32'd1 << 7));
      cfg(32'd1 << 24);
      #1;
      check("R8 flag cleared by write", csr_rdata, 32'd1 << 24);

      // R9: write coincides with input flush event
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = 32'd1 << 24;
      op_valid = 1'b1; op_a = 32'h80000001; op_b = 32'd0;
      @(negedge clk);
      csr_we = 1'b0; op_valid = 1'b0;
      #1;
      check("R9 write beats input flag", csr_rdata, 32'd1 << 24);

      // R9: write coincides with result flush and inexact
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = (32'd1 << 24) | (32'd1 << 4);
      res_valid = 1'b1; res_sign = 1'b0; res_exp = -10'sd5; res_sig = 24'h800000;
      res_nan = 1'b0; res_inexact = 1'b0;
      @(negedge clk);
      csr_we = 1'b0; res_valid = 1'b0;
      #1;
      check("R9 write beats result flags", csr_rdata, (32'd1 << 24) | (32'd1 << 4));

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule